// File: doc/BRIEF.md
# Oscillator Frequency Divider Selector

This block turns a fast on-chip oscillator clock into the system clock. The oscillator runs at 32 MHz or 24 MHz, and a configuration input says which. The block divides that rate by a power of two between 1 and 32. The output is not a new clock net. It is a one-cycle enable pulse on the base clock, named `div_tick`, plus a CPU enable, named `cpu_tick`, that can be held off for a short stall. Software selects the divide ratio through an 8-bit select register. After reset, that register holds a value taken from configuration pins rather than a fixed constant.

A write is accepted only when three things hold: the oscillator is currently the clock source, the code exists for the chosen base rate, and the resulting frequency stays within the ceiling set by the operating-mode input. A write that breaks any of these leaves the register untouched and raises a sticky error flag, which a status-read strobe clears.

An accepted write starts a switch sequence with two phases:
- The output keeps its old rate for three more divided periods.
- The divisor then changes at a period boundary, and the CPU enable is suppressed for three periods at the new rate.

The busy flag covers the whole sequence. Writes that arrive while busy are dropped.

Top module: `osc_div_sel`

## Requirements
- R1: While `rst_n` is low, the select code loads from `cfg_code`, `stat_busy` is 0 and `stat_err` is 0. After release, `div_tick` runs at the ratio of that code.
- R2: `sel_rdata` bits 7:3 always read 0, and bits 2:0 hold the last accepted code. Bits 7:3 of `wr_data` are ignored, and only `wr_data[2:0]` is the code.
- R3: In steady state, `div_tick` is high for one base cycle every 2^code base cycles.
- R4: With `base_hi`=1 (32 MHz), codes 0 to 5 give 32, 16, 8, 4, 2 and 1 MHz. With `base_hi`=0 (24 MHz), codes 0 to 3 give 24, 12, 6 and 3 MHz, and codes 4 and 5 are rejected. Codes 6 and 7 are always rejected.
- R5: `mode` sets a frequency ceiling: 0 gives 4 MHz, 1 gives 8 MHz, 2 gives 16 MHz and 3 gives 32 MHz. A write whose resulting frequency (base >> code) exceeds the ceiling is rejected.
- R6: A write while `src_ok` is 0 is rejected.
- R7: A rejected write leaves `sel_rdata`, `stat_busy` and the `div_tick` period unchanged, and sets `stat_err` on the next cycle. `stat_err` stays high until a `stat_rd` pulse clears it.
- R8: An accepted write raises `stat_busy` in the next cycle and updates `sel_rdata`. A write while busy is ignored and does not set `stat_err`.
- R9: After acceptance, the next three `div_tick` pulses keep the old spacing and each is passed to `cpu_tick`.
- R10: The three `div_tick` pulses that follow use the new rate and are not passed to `cpu_tick`. `stat_busy` falls in the cycle after the third of these, and later pulses reach `cpu_tick` again.
- R11: The divisor changes only at the end of a divided period, so the gap from the last old pulse to the first new pulse equals the new ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_code | input | 3 | Select code loaded at reset |
| base_hi | input | 1 | 1: base is 32 MHz, 0: base is 24 MHz |
| mode | input | 2 | Operating-mode frequency ceiling |
| src_ok | input | 1 | Oscillator currently feeds the CPU/peripheral clock |
| wr_en | input | 1 | Select register write strobe |
| wr_data | input | 8 | Write data, code in bits 2:0 |
| stat_rd | input | 1 | Status read strobe, clears the error flag |
| sel_rdata | output | 8 | Select register readback |
| stat_busy | output | 1 | Switch sequence in progress |
| stat_err | output | 1 | Sticky rejected-write flag |
| div_tick | output | 1 | Divided clock enable for peripherals |
| cpu_tick | output | 1 | CPU clock enable, low during the stall |

## Verification
A wrong phase counter shows as a misplaced change of spacing: the fourth pulse after a write arrives at the old gap, or a suppressed pulse reaches `cpu_tick`. Either is visible within one new period of the switch. A bad legality decision appears one cycle after the write, as an unexpected `stat_err` or readback value. A divisor loaded mid-period shows as a short gap at the switch point. The sweep covers every code under both base rates and all four ceilings, which exposes a wrong entry in the legality decision directly.

// File: rtl/osc_div_pkg.sv
package osc_div_pkg;
    localparam int CODE_W        = 3;
    localparam int MAX_CODE      = 5;
    localparam int LO_MAX_CODE   = 3;
    localparam int HI_BASE_MHZ   = 32;
    localparam int LO_BASE_MHZ   = 24;
    localparam int CEIL_MIN_MHZ  = 4;
    localparam int MHZ_W         = 7;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_OLD   = 2'd1,
        PH_STALL = 2'd2
    } phase_e;
endpackage

// File: rtl/osc_div_check.sv
module osc_div_check
    import osc_div_pkg::*;
(
    input  logic              base_hi,
    input  logic [1:0]        mode,
    input  logic              src_ok,
    input  logic [CODE_W-1:0] code,
    output logic              ok
);
    logic [MHZ_W-1:0] base_mhz;
    logic [MHZ_W-1:0] out_mhz;
    logic [MHZ_W-1:0] ceil_mhz;
    logic             in_range;

    always_comb begin
        base_mhz = base_hi ? MHZ_W'(HI_BASE_MHZ) : MHZ_W'(LO_BASE_MHZ);
        in_range = base_hi ? (code <= CODE_W'(MAX_CODE)) : (code <= CODE_W'(LO_MAX_CODE));
        out_mhz  = base_mhz >> code;
        ceil_mhz = MHZ_W'(CEIL_MIN_MHZ) << mode;
        ok       = src_ok && in_range && (out_mhz <= ceil_mhz);
    end
endmodule

// File: rtl/osc_div_counter.sv
module osc_div_counter
    import osc_div_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t        s_d, s_q;
    logic [CODE_W-1:0] code_c;
    logic [CNT_W-1:0]  last;

    always_comb begin
        code_c = (code > CODE_W'(CNT_W)) ? CODE_W'(CNT_W) : code;
        last   = CNT_W'((32'd1 << code_c) - 32'd1);
        tick   = (s_q.cnt == last);
        s_d    = s_q;
        s_d.cnt = tick ? '0 : s_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R3 / R11: a divisor change never leaves the count beyond the new period end
    p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= last);
endmodule

// File: rtl/osc_div_seq.sv
module osc_div_seq
    import osc_div_pkg::*;
#(
    parameter int OLD_TICKS   = 3,
    parameter int STALL_TICKS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] cfg_code,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              legal,
    input  logic              stat_rd,
    input  logic              tick,
    output logic [CODE_W-1:0] pend_code,
    output logic [CODE_W-1:0] act_code,
    output logic              busy,
    output logic              err,
    output logic              stall
);
    localparam int MAX_TICKS = (OLD_TICKS > STALL_TICKS) ? OLD_TICKS : STALL_TICKS;
    localparam int PH_W      = $clog2(MAX_TICKS + 1);

    typedef struct packed {
        phase_e            phase;
        logic [CODE_W-1:0] pend;
        logic [CODE_W-1:0] act;
        logic [PH_W-1:0]   cnt;
        logic              err;
    } seq_state_t;

    seq_state_t s_d, s_q;
    logic       idle;
    logic       accept;
    logic       reject;

    always_comb begin
        s_d    = s_q;
        idle   = (s_q.phase == PH_IDLE);
        accept = wr_en && idle && legal;
        reject = wr_en && idle && !legal;

        if (stat_rd) s_d.err = 1'b0;
        if (reject)  s_d.err = 1'b1;

        unique case (s_q.phase)
            PH_IDLE: begin
                if (accept) begin
                    s_d.pend  = wr_code;
                    s_d.phase = PH_OLD;
                    s_d.cnt   = '0;
                end
            end
            PH_OLD: begin
                if (tick) begin
                    if (s_q.cnt == PH_W'(OLD_TICKS - 1)) begin
                        s_d.act   = s_q.pend;
                        s_d.phase = PH_STALL;
                        s_d.cnt   = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + PH_W'(1);
                    end
                end
            end
            PH_STALL: begin
                if (tick) begin
                    if (s_q.cnt == PH_W'(STALL_TICKS - 1)) begin
                        s_d.phase = PH_IDLE;
                        s_d.cnt   = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + PH_W'(1);
                    end
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.phase <= PH_IDLE;
            s_q.pend  <= cfg_code;
            s_q.act   <= cfg_code;
            s_q.cnt   <= '0;
            s_q.err   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pend_code = s_q.pend;
    assign act_code  = s_q.act;
    assign busy      = (s_q.phase != PH_IDLE);
    assign err       = s_q.err;
    assign stall     = (s_q.phase == PH_STALL);

    // R7: a refused write raises the sticky flag
    p_err_on_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy && !legal) |=> err);

    // R8: a write during a switch leaves the stored code alone and raises no error
    p_busy_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && busy && !stat_rd) |=> (pend_code == $past(pend_code)) && (err == $past(err)));

    // R11: the active divisor moves only on a period boundary
    p_switch_on_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_code) |-> $past(tick));

    // R10: the stall ends together with a divided pulse
    p_busy_ends_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(tick));
endmodule

// File: rtl/osc_div_sel.sv
module osc_div_sel
    import osc_div_pkg::*;
#(
    parameter int OLD_TICKS   = 3,
    parameter int STALL_TICKS = 3,
    parameter int REG_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cfg_code,
    input  logic             base_hi,
    input  logic [1:0]       mode,
    input  logic             src_ok,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             stat_rd,
    output logic [REG_W-1:0] sel_rdata,
    output logic             stat_busy,
    output logic             stat_err,
    output logic             div_tick,
    output logic             cpu_tick
);
    localparam int CNT_W = MAX_CODE;

    logic [CODE_W-1:0] wr_code;
    logic [CODE_W-1:0] pend_code;
    logic [CODE_W-1:0] act_code;
    logic              legal;
    logic              tick;
    logic              stall;

    assign wr_code = wr_data[CODE_W-1:0];

    osc_div_check i_check (
        .base_hi (base_hi),
        .mode    (mode),
        .src_ok  (src_ok),
        .code    (wr_code),
        .ok      (legal)
    );

    osc_div_counter #(.CNT_W(CNT_W)) i_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .code  (act_code),
        .tick  (tick)
    );

    osc_div_seq #(
        .OLD_TICKS   (OLD_TICKS),
        .STALL_TICKS (STALL_TICKS)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_code  (cfg_code),
        .wr_en     (wr_en),
        .wr_code   (wr_code),
        .legal     (legal),
        .stat_rd   (stat_rd),
        .tick      (tick),
        .pend_code (pend_code),
        .act_code  (act_code),
        .busy      (stat_busy),
        .err       (stat_err),
        .stall     (stall)
    );

    assign sel_rdata = {{(REG_W-CODE_W){1'b0}}, pend_code};
    assign div_tick  = tick;
    assign cpu_tick  = tick && !stall;

    // R7: a refused write does not start a switch
    p_reject_no_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !stat_busy && !legal) |=> !stat_busy);
endmodule

// File: tb/test_osc_div_sel.sv
module test_osc_div_sel;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cfg_code = 3'd0;
    logic       base_hi = 1'b1;
    logic [1:0] mode = 2'd3;
    logic       src_ok = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic       stat_rd = 1'b0;
    logic [7:0] sel_rdata;
    logic       stat_busy, stat_err, div_tick, cpu_tick;

    int total = 0;
    int bad = 0;
    int cur = 0;

    always #2.5 clk = ~clk;

    osc_div_sel i_osc_div_sel (
        .clk(clk), .rst_n(rst_n), .cfg_code(cfg_code), .base_hi(base_hi),
        .mode(mode), .src_ok(src_ok), .wr_en(wr_en), .wr_data(wr_data),
        .stat_rd(stat_rd), .sel_rdata(sel_rdata), .stat_busy(stat_busy),
        .stat_err(stat_err), .div_tick(div_tick), .cpu_tick(cpu_tick)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit exp_legal(input bit b, input int m, input bit s, input int c);
        int f;
        if (!s) return 1'b0;
        if (c > 5) return 1'b0;
        if (!b && c > 3) return 1'b0;
        f = (b ? 32 : 24) >> c;
        return f <= (4 << m);
    endfunction

    function automatic string why(input bit b, input bit s, input int c);
        if (c > 5 || (!b && c > 3)) return "R4";
        if (!s) return "R6";
        return "R5";
    endfunction

    task automatic do_reset(input int c);
        rst_n = 1'b0;
        cfg_code = 3'(c);
        repeat (3) @(negedge clk);
        chk(sel_rdata == 8'(c), "R1", "reset readback", sel_rdata, c);
        chk(stat_busy == 1'b0, "R1", "reset busy", stat_busy, 0);
        chk(stat_err == 1'b0, "R1", "reset err", stat_err, 0);
        rst_n = 1'b1;
        cur = c;
        @(negedge clk);
    endtask

    task automatic measure_period(input int c, input string req);
        int gap;
        while (!div_tick) @(negedge clk);
        @(negedge clk);
        gap = 1;
        while (!div_tick && gap < 100) begin
            @(negedge clk);
            gap++;
        end
        chk(gap == (1 << c), req, "period", gap, 1 << c);
    endtask

    task automatic try_write(input int c, input logic [7:0] data);
        bit ok;
        int t[7];
        bit cp[7];
        bit bs[7];
        int n;
        int cyc;
        string r;
        ok = exp_legal(base_hi, int'(mode), src_ok, c);
        r = why(base_hi, src_ok, c);
        wr_en = 1'b1;
        wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
        if (!ok) begin
            chk(sel_rdata == 8'(cur), r, "rejected readback (R7)", sel_rdata, cur);
            chk(stat_err == 1'b1, r, "error flag (R7)", stat_err, 1);
            chk(stat_busy == 1'b0, "R7", "busy after reject", stat_busy, 0);
            measure_period(cur, "R7");
            chk(stat_err == 1'b1, "R7", "error sticky", stat_err, 1);
            stat_rd = 1'b1;
            @(negedge clk);
            stat_rd = 1'b0;
            chk(stat_err == 1'b0, "R7", "error cleared", stat_err, 0);
        end else begin
            chk(stat_busy == 1'b1, "R8", "busy after accept", stat_busy, 1);
            chk(sel_rdata == 8'(c), "R2", "accepted readback", sel_rdata, c);
            chk(stat_err == 1'b0, "R4", "no error on legal write", stat_err, 0);
            n = 0;
            cyc = 0;
            while (n < 7 && cyc < 2000) begin
                if (div_tick) begin
                    t[n] = cyc;
                    cp[n] = cpu_tick;
                    bs[n] = stat_busy;
                    n++;
                end
                if (n < 7) begin
                    @(negedge clk);
                    cyc++;
                end
            end
            chk(n == 7, "R9", "pulses seen", n, 7);
            if (n == 7) begin
                chk(t[1] - t[0] == (1 << cur), "R9", "old gap 1", t[1] - t[0], 1 << cur);
                chk(t[2] - t[1] == (1 << cur), "R9", "old gap 2", t[2] - t[1], 1 << cur);
                chk(cp[0] && cp[1] && cp[2], "R9", "cpu runs in old phase",
                    int'({cp[0], cp[1], cp[2]}), 7);
                chk(t[3] - t[2] == (1 << c), "R11", "switch gap", t[3] - t[2], 1 << c);
                chk(t[4] - t[3] == (1 << c), "R3", "new gap 1", t[4] - t[3], 1 << c);
                chk(t[5] - t[4] == (1 << c), "R3", "new gap 2", t[5] - t[4], 1 << c);
                chk(!cp[3] && !cp[4] && !cp[5], "R10", "cpu stalled",
                    int'({cp[3], cp[4], cp[5]}), 0);
                chk(bs[5] == 1'b1, "R10", "busy through stall", bs[5], 1);
                chk(bs[6] == 1'b0, "R10", "busy cleared", bs[6], 0);
                chk(cp[6] == 1'b1, "R10", "cpu resumes", cp[6], 1);
            end
            cur = c;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL all watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int a;
        int b2;
        void'($urandom(32'd4711));

        // R1: reset loads the configured code
        do_reset(2);
        measure_period(2, "R1");
        do_reset(0);
        measure_period(0, "R1");

        // R2: upper data bits ignored, upper readback bits zero
        base_hi = 1'b1; mode = 2'd3; src_ok = 1'b1;
        try_write(1, 8'hF9);
        chk(sel_rdata[7:3] == 5'd0, "R2", "upper readback", sel_rdata[7:3], 0);

        // R6: source not selected
        src_ok = 1'b0;
        try_write(3, 8'h03);
        src_ok = 1'b1;

        // R8: write while busy is ignored
        wr_en = 1'b1; wr_data = 8'h02;
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h04;
        @(negedge clk);
        wr_en = 1'b0;
        chk(sel_rdata == 8'h02, "R8", "busy write readback", sel_rdata, 2);
        chk(stat_err == 1'b0, "R8", "busy write no error", stat_err, 0);
        while (stat_busy) @(negedge clk);
        chk(sel_rdata == 8'h02, "R8", "code after switch", sel_rdata, 2);
        cur = 2;
        measure_period(2, "R8");

        // R4 R5: sweep every code, base and ceiling
        for (int bb = 0; bb < 2; bb++) begin
            for (int m = 0; m < 4; m++) begin
                for (int c = 0; c < 8; c++) begin
                    base_hi = bb[0];
                    mode = 2'(m);
                    try_write(c, 8'(c));
                end
            end
        end

        // random mix
        for (int i = 0; i < 40; i++) begin
            base_hi = 1'($urandom);
            mode = 2'($urandom);
            src_ok = ($urandom % 5) != 0;
            a = int'($urandom % 8);
            b2 = int'($urandom % 32);
            try_write(a, {5'(b2), 3'(a)});
        end
        src_ok = 1'b1;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule